// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the entry half of exception handling for a small microcontroller-class processor core. A single start pulse launches it. It takes in an exception number, a return-link value, the vector table base and a snapshot of the caller's registers. It then performs these steps:

- optionally pads the stack pointer to an 8-byte boundary;
- writes an eight-word context frame to memory, one word per handshake, through a single-word write port;
- acknowledges the interrupt controller;
- reads the handler address from the vector table through a single-word read port;
- commits the new program state to the register file with a one-cycle strobe.

A write or read error response stops the sequence without a commit and raises a sticky lockup output. Only reset clears it. While a sequence is in flight the block reports busy and ignores further start pulses. Every sequence ends with a one-cycle done pulse, whether or not it committed.

Top module: `exc_entry_seq`

## Requirements
- R1: At start, all data inputs are captured. If stack-pointer bit 2 is 1 and `align_en_i` is 1, the stack pointer is reduced by 4 before stacking and bit 9 of the stacked status word is set. Otherwise the stack pointer is used unchanged and status bit 9 is passed through as supplied.
- R2: Eight words are written with predecrement addressing. The k-th write (k = 0..7) goes to SP' - 4·(k+1), where SP' is the stack pointer after R1. The data order is status, PC, LR, R12, R3, R2, R1, R0.
- R3: A write or read request keeps its valid, address and data steady until the cycle in which ready is seen. Exactly one word moves per valid-and-ready cycle.
- R4: The vector is read from `vec_base_i + 4·exc_num_i`.
- R5: On commit, `new_pc_o` equals the fetched vector with bit 0 cleared, and `new_tbit_o` equals bit 0 of the fetched vector.
- R6: On commit, the following hold: `stack_sel_o` is 0, `it_clear_o` is 1, `new_lr_o` equals the captured return link, and `new_sp_o` equals SP' - 32.
- R7: `ack_o` pulses exactly once per sequence that stacks all eight words. The pulse comes after the last write and before the vector read is issued.
- R8: A read error response suppresses the commit, ends the sequence and sets `lockup_o`. `lockup_o` then stays 1 until reset.
- R9: A write error response ends the sequence at that word, with no acknowledge, no vector read and no commit, and sets `lockup_o`.
- R10: A start pulse while busy is ignored. The running sequence keeps its captured exception number and makes no extra transfers.
- R11: `busy_o` is 1 from the cycle after start until the done pulse, inclusive. `done_o` is a single-cycle pulse, and `busy_o` is 0 in the following cycle.
- R12: After reset, `busy_o`, `done_o`, `ack_o`, `commit_o`, `mem_wr_valid_o`, `mem_rd_valid_o` and `lockup_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse |
| exc_num_i | input | EXC_W | Exception number to take |
| link_i | input | DW | Return-link value for the handler's link register |
| vec_base_i | input | DW | Vector table base address |
| align_en_i | input | 1 | Enables 8-byte stack alignment |
| sp_i | input | DW | Current stack pointer |
| psr_i | input | DW | Current status word |
| pc_i | input | DW | Current program counter |
| lr_i | input | DW | Current link register |
| r12_i | input | DW | Register 12 |
| r3_i | input | DW | Register 3 |
| r2_i | input | DW | Register 2 |
| r1_i | input | DW | Register 1 |
| r0_i | input | DW | Register 0 |
| mem_wr_valid_o | output | 1 | Write request valid |
| mem_wr_addr_o | output | DW | Write address |
| mem_wr_data_o | output | DW | Write data |
| mem_wr_ready_i | input | 1 | Write accepted |
| mem_wr_err_i | input | 1 | Write error response, sampled with ready |
| mem_rd_valid_o | output | 1 | Read request valid |
| mem_rd_addr_o | output | DW | Read address |
| mem_rd_ready_i | input | 1 | Read data returned |
| mem_rd_data_i | input | DW | Read data |
| mem_rd_err_i | input | 1 | Read error response, sampled with ready |
| ack_o | output | 1 | Interrupt controller acknowledge pulse |
| commit_o | output | 1 | Register file update strobe |
| new_pc_o | output | DW | Handler entry address |
| new_tbit_o | output | 1 | Instruction-set state bit |
| new_lr_o | output | DW | New link register value |
| new_sp_o | output | DW | New stack pointer |
| stack_sel_o | output | 1 | Stack select (0 = main stack) |
| it_clear_o | output | 1 | Clears conditional-execution state |
| busy_o | output | 1 | Sequence in flight |
| done_o | output | 1 | Sequence finished pulse |
| lockup_o | output | 1 | Sticky error indication |

## Verification
On every cycle, the embedded assertions check the following:
- request stability under back-pressure on both memory ports;
- stickiness of lockup;
- the abort paths after an error response;
- the ordering of acknowledge before the vector read, and of commit before done;
- the busy and done shape.

Only the bench scenarios can show the rest:
- the exact stacked addresses and the word order;
- the conditional alignment pad and status bit 9;
- the vector address arithmetic;
- the split of the vector into program counter and state bit;
- the fact that a start pulse during a sequence leaves the captured exception number untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ALIGN  = 3'd1,
      ST_PUSH   = 3'd2,
      ST_ACK    = 3'd3,
      ST_VREAD  = 3'd4,
      ST_COMMIT = 3'd5,
      ST_DONE   = 3'd6
   } seq_state_e;

   // number of words in a context frame
   localparam int FRAME_WORDS    = 8;
   // status bit recording that a pad word was inserted
   localparam int ALIGN_FLAG_BIT = 9;

endpackage

// File: rtl/exc_align_unit.sv
module exc_align_unit
   import exc_entry_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit HAS_ALIGN = 1'b1
) (
   input  logic [DW-1:0] sp_i,
   input  logic [DW-1:0] psr_i,
   input  logic          en_i,
   output logic [DW-1:0] sp_o,
   output logic [DW-1:0] psr_o
);

   generate
      if (HAS_ALIGN) begin : g_align
         logic pad;
         always_comb begin
            pad   = en_i & sp_i[2];
            sp_o  = pad ? (sp_i - DW'(4)) : sp_i;
            psr_o = psr_i;
            if (pad) psr_o[ALIGN_FLAG_BIT] = 1'b1;
         end
      end else begin : g_noalign
         assign sp_o  = sp_i;
         assign psr_o = psr_i;
      end
   endgenerate

endmodule

// File: rtl/exc_frame_sel.sv
module exc_frame_sel
   import exc_entry_pkg::*;
#(
   parameter int DW = 32,
   localparam int IW = $clog2(FRAME_WORDS)
) (
   input  logic [IW-1:0] idx_i,
   input  logic [DW-1:0] psr_i,
   input  logic [DW-1:0] pc_i,
   input  logic [DW-1:0] lr_i,
   input  logic [DW-1:0] r12_i,
   input  logic [DW-1:0] r3_i,
   input  logic [DW-1:0] r2_i,
   input  logic [DW-1:0] r1_i,
   input  logic [DW-1:0] r0_i,
   output logic [DW-1:0] word_o
);

   logic [DW-1:0] slot [FRAME_WORDS];

   // push order: highest address first
   assign slot[0] = psr_i;
   assign slot[1] = pc_i;
   assign slot[2] = lr_i;
   assign slot[3] = r12_i;
   assign slot[4] = r3_i;
   assign slot[5] = r2_i;
   assign slot[6] = r1_i;
   assign slot[7] = r0_i;

   assign word_o = slot[idx_i];

endmodule

// File: rtl/exc_vec_unit.sv
module exc_vec_unit #(
   parameter int DW    = 32,
   parameter int EXC_W = 9
) (
   input  logic [DW-1:0]    base_i,
   input  logic [EXC_W-1:0] num_i,
   input  logic [DW-1:0]    vec_i,
   output logic [DW-1:0]    addr_o,
   output logic [DW-1:0]    pc_o,
   output logic             tbit_o
);

   logic [DW-1:0] offset;

   assign offset = DW'({num_i, 2'b00});
   assign addr_o = base_i + offset;
   assign pc_o   = {vec_i[DW-1:1], 1'b0};
   assign tbit_o = vec_i[0];

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int DW        = 32,
   parameter int EXC_W     = 9,
   parameter bit HAS_ALIGN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [EXC_W-1:0] exc_num_i,
   input  logic [DW-1:0]    link_i,
   input  logic [DW-1:0]    vec_base_i,
   input  logic             align_en_i,
   input  logic [DW-1:0]    sp_i,
   input  logic [DW-1:0]    psr_i,
   input  logic [DW-1:0]    pc_i,
   input  logic [DW-1:0]    lr_i,
   input  logic [DW-1:0]    r12_i,
   input  logic [DW-1:0]    r3_i,
   input  logic [DW-1:0]    r2_i,
   input  logic [DW-1:0]    r1_i,
   input  logic [DW-1:0]    r0_i,
   output logic             mem_wr_valid_o,
   output logic [DW-1:0]    mem_wr_addr_o,
   output logic [DW-1:0]    mem_wr_data_o,
   input  logic             mem_wr_ready_i,
   input  logic             mem_wr_err_i,
   output logic             mem_rd_valid_o,
   output logic [DW-1:0]    mem_rd_addr_o,
   input  logic             mem_rd_ready_i,
   input  logic [DW-1:0]    mem_rd_data_i,
   input  logic             mem_rd_err_i,
   output logic             ack_o,
   output logic             commit_o,
   output logic [DW-1:0]    new_pc_o,
   output logic             new_tbit_o,
   output logic [DW-1:0]    new_lr_o,
   output logic [DW-1:0]    new_sp_o,
   output logic             stack_sel_o,
   output logic             it_clear_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             lockup_o
);

   localparam int IW       = $clog2(FRAME_WORDS);
   localparam int LAST_IDX = FRAME_WORDS - 1;

   generate
      if (DW < 16) begin : g_chk_dw
         $error("exc_entry_seq: DW must be at least 16");
      end
      if (EXC_W < 1 || EXC_W > DW - 2) begin : g_chk_exc
         $error("exc_entry_seq: EXC_W out of range");
      end
   endgenerate

   seq_state_e       state_q;
   logic [IW-1:0]    idx_q;
   logic [DW-1:0]    sp_q, psr_q, pc_q, lr_q, r12_q, r3_q, r2_q, r1_q, r0_q;
   logic [DW-1:0]    link_q, base_q, vec_q;
   logic [EXC_W-1:0] num_q;
   logic             align_q;
   logic             lock_q;

   logic [DW-1:0]    sp_al, psr_al, push_word, vec_addr;
   logic             wr_fire, rd_fire;

   exc_align_unit #(.DW(DW), .HAS_ALIGN(HAS_ALIGN)) u_align (
      .sp_i  (sp_q),
      .psr_i (psr_q),
      .en_i  (align_q),
      .sp_o  (sp_al),
      .psr_o (psr_al)
   );

   exc_frame_sel #(.DW(DW)) u_frame (
      .idx_i  (idx_q),
      .psr_i  (psr_q),
      .pc_i   (pc_q),
      .lr_i   (lr_q),
      .r12_i  (r12_q),
      .r3_i   (r3_q),
      .r2_i   (r2_q),
      .r1_i   (r1_q),
      .r0_i   (r0_q),
      .word_o (push_word)
   );

   exc_vec_unit #(.DW(DW), .EXC_W(EXC_W)) u_vec (
      .base_i (base_q),
      .num_i  (num_q),
      .vec_i  (vec_q),
      .addr_o (vec_addr),
      .pc_o   (new_pc_o),
      .tbit_o (new_tbit_o)
   );

   assign mem_wr_valid_o = (state_q == ST_PUSH);
   assign mem_wr_addr_o  = sp_q - DW'(4);
   assign mem_wr_data_o  = push_word;
   assign mem_rd_valid_o = (state_q == ST_VREAD);
   assign mem_rd_addr_o  = vec_addr;
   assign wr_fire        = mem_wr_valid_o & mem_wr_ready_i;
   assign rd_fire        = mem_rd_valid_o & mem_rd_ready_i;

   assign ack_o       = (state_q == ST_ACK);
   assign commit_o    = (state_q == ST_COMMIT);
   assign done_o      = (state_q == ST_DONE);
   assign busy_o      = (state_q != ST_IDLE);
   assign new_lr_o    = link_q;
   assign new_sp_o    = sp_q;
   assign stack_sel_o = 1'b0;
   assign it_clear_o  = commit_o;
   assign lockup_o    = lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         sp_q    <= '0;
         psr_q   <= '0;
         pc_q    <= '0;
         lr_q    <= '0;
         r12_q   <= '0;
         r3_q    <= '0;
         r2_q    <= '0;
         r1_q    <= '0;
         r0_q    <= '0;
         link_q  <= '0;
         base_q  <= '0;
         vec_q   <= '0;
         num_q   <= '0;
         align_q <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  sp_q    <= sp_i;
                  psr_q   <= psr_i;
                  pc_q    <= pc_i;
                  lr_q    <= lr_i;
                  r12_q   <= r12_i;
                  r3_q    <= r3_i;
                  r2_q    <= r2_i;
                  r1_q    <= r1_i;
                  r0_q    <= r0_i;
                  link_q  <= link_i;
                  base_q  <= vec_base_i;
                  num_q   <= exc_num_i;
                  align_q <= align_en_i;
                  state_q <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               sp_q    <= sp_al;
               psr_q   <= psr_al;
               idx_q   <= '0;
               state_q <= ST_PUSH;
            end
            ST_PUSH: begin
               if (wr_fire) begin
                  sp_q  <= sp_q - DW'(4);
                  idx_q <= idx_q + 1'b1;
                  if (mem_wr_err_i) begin
                     lock_q  <= 1'b1;
                     state_q <= ST_DONE;
                  end else if (idx_q == IW'(LAST_IDX)) begin
                     state_q <= ST_ACK;
                  end
               end
            end
            ST_ACK: state_q <= ST_VREAD;
            ST_VREAD: begin
               if (rd_fire) begin
                  if (mem_rd_err_i) begin
                     lock_q  <= 1'b1;
                     state_q <= ST_DONE;
                  end else begin
                     vec_q   <= mem_rd_data_i;
                     state_q <= ST_COMMIT;
                  end
               end
            end
            ST_COMMIT: state_q <= ST_DONE;
            ST_DONE:   state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   // R3: requests held steady under back-pressure
   a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid_o && !mem_wr_ready_i |=>
         mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));
   a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));
   // R7: acknowledge is followed directly by the vector read
   a_r7_ack_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> mem_rd_valid_o && !ack_o);
   // R8: read error aborts without commit and locks up
   a_r8_rd_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && mem_rd_err_i |=> done_o && lockup_o && !commit_o);
   a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lockup_o |=> lockup_o);
   // R9: write error aborts without acknowledge
   a_r9_wr_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && mem_wr_err_i |=> done_o && lockup_o && !ack_o && !mem_rd_valid_o);
   // R6: commit is followed by done
   a_r6_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> done_o && !commit_o);
   // R10: captured exception number cannot change mid-sequence
   a_r10_num_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> $stable(mem_rd_addr_o) || !$past(mem_rd_valid_o));
   // R11: busy shape
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o && !done_o);
   a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;

   localparam int DW    = 32;
   localparam int EXC_W = 9;

   typedef struct packed {
      logic [31:0] sp;
      logic        en;
      logic [8:0]  num;
      logic [31:0] base;
      logic [31:0] vec;
      logic [1:0]  lat;
   } tcase_t;

   localparam int NCASE = 5;
   localparam tcase_t TBL [NCASE] = '{
      '{32'h2000_0FFC, 1'b1, 9'd16,  32'h0000_0000, 32'h0000_0401, 2'd0},
      '{32'h2000_0FFC, 1'b0, 9'd3,   32'h1000_0000, 32'h0800_0101, 2'd1},
      '{32'h2000_0FF8, 1'b1, 9'd11,  32'h0000_4000, 32'h0000_2000, 2'd2},
      '{32'h2000_1004, 1'b1, 9'd511, 32'h2000_0000, 32'hFFFF_FFFF, 2'd3},
      '{32'h3000_0000, 1'b1, 9'd1,   32'h0000_0000, 32'h0000_00C9, 2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [EXC_W-1:0] exc_num_i = '0;
   logic [DW-1:0] link_i = '0, vec_base_i = '0, sp_i = '0, psr_i = '0, pc_i = '0;
   logic [DW-1:0] lr_i = '0, r12_i = '0, r3_i = '0, r2_i = '0, r1_i = '0, r0_i = '0;
   logic align_en_i = 1'b0;
   logic mem_wr_valid_o, mem_rd_valid_o;
   logic [DW-1:0] mem_wr_addr_o, mem_wr_data_o, mem_rd_addr_o;
   logic mem_wr_ready_i = 1'b0, mem_wr_err_i = 1'b0;
   logic mem_rd_ready_i = 1'b0, mem_rd_err_i = 1'b0;
   logic [DW-1:0] mem_rd_data_i = '0;
   logic ack_o, commit_o, new_tbit_o, stack_sel_o, it_clear_o, busy_o, done_o, lockup_o;
   logic [DW-1:0] new_pc_o, new_lr_o, new_sp_o;

   always #2 clk = ~clk;

   exc_entry_seq #(.DW(DW), .EXC_W(EXC_W)) u0 (.*);

   // memory model and monitor state (written only by the responder)
   logic [31:0] wa [256];
   logic [31:0] wd [256];
   int wn = 0, rn = 0, ack_n = 0, done_n = 0, commit_n = 0;
   logic [31:0] last_ra;
   logic [31:0] c_pc, c_lr, c_sp;
   logic c_t, c_sel, c_itc;
   // set only by the main process
   int mem_lat = 0;
   int wr_err_at = -1;
   logic [31:0] rd_vec = '0;
   logic rd_bad = 1'b0;

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin : responder
      int wc, rc;
      wc = 0; rc = 0;
      forever begin
         @(negedge clk);
         if (ack_o) ack_n++;
         if (done_o) done_n++;
         if (commit_o) begin
            commit_n++;
            c_pc = new_pc_o; c_t = new_tbit_o; c_lr = new_lr_o; c_sp = new_sp_o;
            c_sel = stack_sel_o; c_itc = it_clear_o;
         end
         if (mem_wr_ready_i) begin
            mem_wr_ready_i = 1'b0; mem_wr_err_i = 1'b0;
         end else if (mem_wr_valid_o) begin
            if (wc >= mem_lat) begin
               wa[wn % 256] = mem_wr_addr_o;
               wd[wn % 256] = mem_wr_data_o;
               mem_wr_err_i = (wn == wr_err_at);
               mem_wr_ready_i = 1'b1;
               wn++; wc = 0;
            end else wc++;
         end
         if (mem_rd_ready_i) begin
            mem_rd_ready_i = 1'b0; mem_rd_err_i = 1'b0;
         end else if (mem_rd_valid_o) begin
            if (rc >= mem_lat) begin
               last_ra = mem_rd_addr_o;
               mem_rd_data_i = rd_vec;
               mem_rd_err_i = rd_bad;
               mem_rd_ready_i = 1'b1;
               rn++; rc = 0;
            end else rc++;
         end
      end
   end

   task automatic run(input tcase_t tc, input int idx, input int restart_at, output bit timed_out);
      int d0;
      d0 = done_n;
      timed_out = 1'b0;
      @(negedge clk);
      sp_i = tc.sp; align_en_i = tc.en; exc_num_i = tc.num; vec_base_i = tc.base;
      psr_i = 32'h0100_0000 + 32'(idx); pc_i = 32'h0000_1000 + 32'(idx);
      lr_i = 32'hFFFF_FFF0 + 32'(idx); r12_i = 32'hC000_0000 + 32'(idx);
      r3_i = 32'h3333_0000 + 32'(idx); r2_i = 32'h2222_0000 + 32'(idx);
      r1_i = 32'h1111_0000 + 32'(idx); r0_i = 32'h0A0A_0000 + 32'(idx);
      link_i = 32'hFFFF_FFF9 - 32'(idx);
      mem_lat = int'(tc.lat); rd_vec = tc.vec;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < 300; c++) begin
         if (c == restart_at) begin
            start_i = 1'b1; exc_num_i = tc.num + 9'd7;
         end else start_i = 1'b0;
         if (done_n != d0) break;
         @(negedge clk);
      end
      start_i = 1'b0;
      if (done_n == d0) timed_out = 1'b1;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      bit to;
      int w0, a0, c0, r0n;
      logic [31:0] spx, psrx;
      logic [31:0] exp_w [8];

      repeat (3) @(negedge clk);
      // R12: reset state
      chk(!busy_o && !done_o && !ack_o && !commit_o, "R12 reset idle", {28'd0, busy_o, done_o, ack_o, commit_o}, 32'd0);
      chk(!mem_wr_valid_o && !mem_rd_valid_o && !lockup_o, "R12 reset ports", {29'd0, mem_wr_valid_o, mem_rd_valid_o, lockup_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NCASE; i++) begin
         w0 = wn; a0 = ack_n; c0 = commit_n; r0n = rn;
         run(TBL[i], i, (i == 2) ? 5 : -1, to);
         chk(!to, "R11 sequence completes", {31'd0, to}, 32'd0);
         spx  = TBL[i].sp;
         psrx = 32'h0100_0000 + 32'(i);
         if (TBL[i].en && spx[2]) begin spx = spx - 32'd4; psrx[9] = 1'b1; end
         exp_w[0] = psrx;                   exp_w[1] = 32'h0000_1000 + 32'(i);
         exp_w[2] = 32'hFFFF_FFF0 + 32'(i); exp_w[3] = 32'hC000_0000 + 32'(i);
         exp_w[4] = 32'h3333_0000 + 32'(i); exp_w[5] = 32'h2222_0000 + 32'(i);
         exp_w[6] = 32'h1111_0000 + 32'(i); exp_w[7] = 32'h0A0A_0000 + 32'(i);
         chk(wn - w0 == 8, "R3 eight writes (R10 no extra)", 32'(wn - w0), 32'd8);
         for (int k = 0; k < 8; k++) begin
            chk(wa[(w0 + k) % 256] == spx - 32'(4 * (k + 1)), "R1/R2 push address",
                wa[(w0 + k) % 256], spx - 32'(4 * (k + 1)));
            chk(wd[(w0 + k) % 256] == exp_w[k], "R1/R2 push data", wd[(w0 + k) % 256], exp_w[k]);
         end
         chk(ack_n - a0 == 1, "R7 one ack", 32'(ack_n - a0), 32'd1);
         chk(rn - r0n == 1, "R3 one read", 32'(rn - r0n), 32'd1);
         chk(last_ra == TBL[i].base + {21'd0, TBL[i].num, 2'b00}, "R4/R10 vector address",
             last_ra, TBL[i].base + {21'd0, TBL[i].num, 2'b00});
         chk(commit_n - c0 == 1, "R6 one commit", 32'(commit_n - c0), 32'd1);
         chk(c_pc == {TBL[i].vec[31:1], 1'b0}, "R5 new pc", c_pc, {TBL[i].vec[31:1], 1'b0});
         chk(c_t == TBL[i].vec[0], "R5 state bit", {31'd0, c_t}, {31'd0, TBL[i].vec[0]});
         chk(c_lr == 32'hFFFF_FFF9 - 32'(i), "R6 link", c_lr, 32'hFFFF_FFF9 - 32'(i));
         chk(c_sp == spx - 32'd32, "R6 new sp", c_sp, spx - 32'd32);
         chk(!c_sel && c_itc, "R6 main stack, IT clear", {30'd0, c_sel, c_itc}, 32'd1);
         @(negedge clk);
         chk(!busy_o && !done_o, "R11 idle after done", {30'd0, busy_o, done_o}, 32'd0);
         chk(!lockup_o, "R8 no lockup on clean run", {31'd0, lockup_o}, 32'd0);
      end

      // R8: read error
      rd_bad = 1'b1;
      c0 = commit_n;
      run(TBL[0], 0, -1, to);
      rd_bad = 1'b0;
      chk(commit_n == c0, "R8 no commit on read error", 32'(commit_n - c0), 32'd0);
      @(negedge clk);
      chk(lockup_o, "R8 lockup set", {31'd0, lockup_o}, 32'd1);
      run(TBL[1], 1, -1, to);
      chk(lockup_o, "R8 lockup sticky", {31'd0, lockup_o}, 32'd1);

      // R9: write error on fourth word
      rst_n = 1'b0;
      @(negedge clk);
      chk(!lockup_o, "R12 reset clears lockup", {31'd0, lockup_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      w0 = wn; a0 = ack_n; c0 = commit_n; r0n = rn;
      wr_err_at = wn + 3;
      run(TBL[4], 4, -1, to);
      wr_err_at = -1;
      chk(!to, "R9 sequence ends", {31'd0, to}, 32'd0);
      chk(wn - w0 == 4, "R9 stops at failing word", 32'(wn - w0), 32'd4);
      chk(ack_n == a0 && rn == r0n && commit_n == c0, "R9 no ack/read/commit",
          32'(ack_n - a0 + rn - r0n + commit_n - c0), 32'd0);
      @(negedge clk);
      chk(lockup_o, "R9 lockup set", {31'd0, lockup_o}, 32'd1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule